// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block is a serial-bus slave that lets a host read and write a bank of byte-wide registers. The host can use four transaction types: single-byte write, single-byte read, two-byte write and two-byte read. The register bank has sixteen locations, and each one is a byte. In a two-byte write, the first data byte is stored and the second is acknowledged and then dropped. In a two-byte read, the slave returns the addressed byte twice.

The data line is handled as two separate signals. A receive input carries every incoming bit. A pull-down enable output drives the line low, and it does so only for acknowledge bits and for zero bits of read data. This lets the block sit behind one-way isolators. Without isolators, the board ties the two signals together onto one open-drain line. Both bus inputs pass through a synchronizer on the system clock, so the bus clock must be several system clocks slower than the system clock.

The register-file side is a plain port with no handshake. The write strobe lasts one cycle, and the file must accept the write in that cycle. Read data is combinational from the register address, and it is sampled at the moment a read begins. The block exerts no back-pressure.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0,0,1 followed by the four `dev_pins` bits. Any other address gets no acknowledge, and the slave then neither acknowledges nor writes anything until the next START or STOP.
- R2: Bits 3:0 of the command byte select the register shown on `reg_addr`. Bits 7:4 of the command byte have no effect.
- R3: In a single-byte write (START, address with bit0=0, command, data, STOP), the data byte appears on `reg_wdata` with `reg_addr` equal to the command nibble, during a `reg_we` pulse one cycle long.
- R4: In a two-byte write, the second data byte is acknowledged but produces no `reg_we` pulse. Any further bytes are treated the same way.
- R5: After a repeated START and an address with bit0=1, the slave sends the selected register MSB first. `sda_oe` is asserted only for zero bits.
- R6: When the host acknowledges a read byte, the next byte sent equals the first, even if the register changed in the meantime.
- R7: When the host does not acknowledge a read byte, the slave releases the line and stays released until STOP or START.
- R8: The register pointer keeps the last command value. A read that has no command phase returns the register that was selected most recently.
- R9: Each accepted byte is acknowledged by `sda_oe` being high during the ninth clock. `sda_oe` changes only while the synchronized SCL is low.
- R10: A START or STOP restarts the bit and byte count from any state, including in the middle of a byte. A STOP releases `sda_oe`.
- R11: After reset, `sda_oe` and `reg_we` are low and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data receive input |
| sda_oe | output | 1 | 1 = pull bus data low |
| dev_pins | input | 4 | Strapped low four bits of the slave address |
| reg_addr | output | 4 | Register pointer toward the register file |
| reg_wdata | output | 8 | Write data toward the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register file at `reg_addr` |

## Verification
The bench changes a register between the two bytes of a word read. A design that reloads the byte would return the new value instead of repeating the first one. It also sends an address that differs only in bit a0 and then sends a further byte. A design with loose address matching would acknowledge that address or issue a stray write. Other tests read without a command phase, clock a byte after a host NACK, and abort an address with a STOP after four bits. These catch a pointer that resets, a slave that keeps driving after NACK, and bit counters that survive a STOP. Word writes are scored against a queue of expected writes, so a strobe for a discarded second byte is reported.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_WDISC,
    ST_RDATA,
    ST_SKIP
  } smb_state_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter int PIN_W       = 4,
  parameter int ADDR_W      = 7,
  parameter logic [ADDR_W-PIN_W-1:0] DEV_PREFIX = 3'b001,
  parameter int REG_AW      = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [PIN_W-1:0]  dev_pins,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DW-1:0]     reg_wdata,
  output logic              reg_we,
  input  logic [DW-1:0]     reg_rdata
);
  import smb_pkg::*;

  localparam int BCW = $clog2(DW + 2);
  localparam logic [BCW-1:0] LAST = BCW'(DW);
  localparam logic [BCW-1:0] ACKC = BCW'(DW + 1);

  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  smb_state_t state;
  logic [BCW-1:0]    bitcnt;
  logic [DW-1:0]     shreg, txbyte, txsh;
  logic [REG_AW-1:0] ptr;
  logic              mack;
  logic              addr_match, rx_state;

  smb_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
  );

  smb_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign addr_match = (shreg[DW-1 -: ADDR_W] == {DEV_PREFIX, dev_pins});
  assign rx_state   = (state == ST_ADDR) || (state == ST_CMD) ||
                      (state == ST_WDATA) || (state == ST_WDISC);
  assign reg_addr   = ptr;
  assign reg_wdata  = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txbyte <= '0;
      txsh   <= '0;
      ptr    <= '0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (bitcnt < LAST) begin
          if (rx_state) shreg <= {shreg[DW-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (bitcnt == LAST) begin
          if (state == ST_RDATA) mack <= ~sda_s;
          bitcnt <= ACKC;
        end
      end else if (scl_fall) begin
        if (bitcnt == LAST) begin
          // entering the acknowledge slot
          case (state)
            ST_ADDR:           sda_oe <= addr_match;
            ST_CMD, ST_WDISC:  sda_oe <= 1'b1;
            ST_WDATA: begin
              sda_oe <= 1'b1;
              reg_we <= 1'b1;
            end
            default:           sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == ACKC) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (state)
            ST_ADDR: begin
              if (!addr_match) state <= ST_SKIP;
              else if (shreg[0]) begin
                state  <= ST_RDATA;
                txbyte <= reg_rdata;
                txsh   <= {reg_rdata[DW-2:0], 1'b0};
                sda_oe <= ~reg_rdata[DW-1];
              end else state <= ST_CMD;
            end
            ST_CMD: begin
              ptr   <= shreg[REG_AW-1:0];
              state <= ST_WDATA;
            end
            ST_WDATA, ST_WDISC: state <= ST_WDISC;
            ST_RDATA: begin
              if (mack) begin
                txsh   <= {txbyte[DW-2:0], 1'b0};
                sda_oe <= ~txbyte[DW-1];
              end else state <= ST_SKIP;
            end
            default: ;
          endcase
        end else if (state == ST_RDATA && bitcnt != '0) begin
          sda_oe <= ~txsh[DW-1];
          txsh   <= {txsh[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              stop_det,
  input smb_pkg::smb_state_t state
);
  import smb_pkg::*;

  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);

  p_first_byte_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(state) == ST_WDATA));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_addr(reg_addr), .stop_det(stop_det), .state(state)
);

// File: tb/smb_reg_slave_tb.sv
module smb_reg_slave_tb_top;
  localparam int Q = 10;
  localparam logic [3:0] PINS = 4'b1010;
  localparam logic [7:0] AW  = {3'b001, PINS, 1'b0};
  localparam logic [7:0] AR  = {3'b001, PINS, 1'b1};
  localparam logic [7:0] AX  = {3'b001, PINS ^ 4'b0001, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  wire  sda_line = m_sda & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];

  logic [7:0] rf [16];
  logic       poke_en = 1'b0;
  logic [3:0] poke_a  = '0;
  logic [7:0] poke_d  = '0;

  always #4 clk = ~clk;

  smb_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .dev_pins(PINS), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // register file environment
  initial for (int i = 0; i < 16; i++) rf[i] = 8'(i * 17);
  always @(posedge clk) begin
    if (reg_we)  rf[reg_addr] <= reg_wdata;
    if (poke_en) rf[poke_a]   <= poke_d;
  end
  assign reg_rdata = rf[reg_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q);
    r = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  task automatic set_cmd_read(input logic [7:0] cmd);
    logic a;
    bus_start();
    send_byte(AW, a);  chk(a, "R1 addr W ack", a, 1);
    send_byte(cmd, a); chk(a, "R9 cmd ack", a, 1);
    bus_start();
    send_byte(AR, a);  chk(a, "R5 addr R ack", a, 1);
  endtask

  logic a;
  logic [7:0] d;
  logic [7:0] exp_r2;

  initial begin
    tick(5);
    chk(sda_oe == 1'b0, "R11 sda_oe reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R11 reg_we reset", reg_we, 0);
    chk(reg_addr == 4'd0, "R11 reg_addr reset", reg_addr, 0);
    rst_n = 1'b1;
    tick(5);

    // R3 / R2: write byte, command upper nibble nonzero
    bus_start();
    send_byte(AW, a);    chk(a, "R1 addr ack", a, 1);
    send_byte(8'hA5, a); chk(a, "R2 cmd ack", a, 1);
    exp_q.push_back({4'h5, 8'h3C});
    send_byte(8'h3C, a); chk(a, "R9 data ack", a, 1);
    bus_stop();
    chk(reg_addr == 4'h5, "R2 pointer from low nibble", reg_addr, 5);

    // R4: write word, second byte acked but not stored
    bus_start();
    send_byte(AW, a);    chk(a, "R4 addr ack", a, 1);
    send_byte(8'h02, a); chk(a, "R4 cmd ack", a, 1);
    exp_q.push_back({4'h2, 8'h81});
    send_byte(8'h81, a); chk(a, "R4 first data ack", a, 1);
    send_byte(8'h7E, a); chk(a, "R4 second data ack", a, 1);
    bus_stop();

    // R5: read byte
    set_cmd_read(8'h05);
    recv_byte(1'b0, d);  chk(d == 8'h3C, "R5 read byte", d, 8'h3C);
    bus_stop();

    // R6: read word, register changes between bytes
    set_cmd_read(8'h02);
    recv_byte(1'b1, d);  chk(d == 8'h81, "R4 R6 first byte", d, 8'h81);
    poke_a = 4'h2; poke_d = 8'h55; poke_en = 1'b1; tick(1); poke_en = 1'b0;
    exp_r2 = 8'h55;
    recv_byte(1'b0, d);  chk(d == 8'h81, "R6 second byte repeats", d, 8'h81);
    bus_stop();

    // R8 / R7: read without command, then NACK releases line
    bus_start();
    send_byte(AR, a);    chk(a, "R8 addr R ack", a, 1);
    recv_byte(1'b0, d);  chk(d == exp_r2, "R8 pointer kept", d, exp_r2);
    recv_byte(1'b0, d);  chk(d == 8'hFF, "R7 released after NACK", d, 8'hFF);
    bus_stop();

    // R1: mismatch in a0, following byte also ignored
    bus_start();
    send_byte(AX, a);    chk(!a, "R1 mismatch no ack", a, 0);
    send_byte(8'h03, a); chk(!a, "R1 ignored byte no ack", a, 0);
    send_byte(8'h99, a); chk(!a, "R1 ignored data no ack", a, 0);
    bus_stop();

    // R10: STOP in mid address, then a clean write
    bus_start();
    for (int i = 7; i >= 4; i--) begin
      logic r;
      clk_bit(AW[i], r);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    bus_start();
    send_byte(AW, a);    chk(a, "R10 addr ack after abort", a, 1);
    send_byte(8'hF7, a); chk(a, "R10 cmd ack", a, 1);
    exp_q.push_back({4'h7, 8'hC3});
    send_byte(8'hC3, a); chk(a, "R10 data ack", a, 1);
    bus_stop();

    set_cmd_read(8'h07);
    recv_byte(1'b0, d);  chk(d == 8'hC3, "R3 readback", d, 8'hC3);
    bus_stop();
    tick(5);
    chk(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule